// File: doc/BRIEF.md
# Dual-Operand Prefetch Address Unit

This block produces the two operand read addresses that a multiply-accumulate instruction needs in a single cycle. One address targets the X data space and the other targets the Y data space. The block holds four prefetch pointer registers, numbered 8 to 11 in the register file. Registers 8 and 9 always feed the X side, and registers 10 and 11 always feed the Y side. For each side, the instruction decoder gives a register number and a 3-bit addressing-mode code.

The block forms each effective address from the selected pointer. It checks that address against the programmable window of that side. When the pointer is post-modified, it also checks the modified value. The block then issues a read strobe and presents the post-modified pointer for writeback, which takes effect on the next clock edge. A separate load port initialises the pointers.

Any selection, mode or address that breaks the rules is flagged on that side. In that case the side issues no strobe and leaves its pointer unchanged.

Top module: `dual_prefetch_agu`

## Requirements
- R1: After reset, all four pointers hold zero.
- R2: The X side accepts register numbers 8 and 9 only, and the Y side accepts 10 and 11 only. Any other number with a non-zero mode code raises that side's illegal flag, with no strobe, no error and no writeback.
- R3: Mode code 1 (indirect) issues the selected pointer as the address and leaves the pointer unchanged.
- R4: Mode codes 2, 3 and 4 issue the pointer's current value as the address. On the following clock edge, the pointer is replaced by that value plus 2, 4 or 6 respectively, and this new value appears on the writeback output in the issue cycle.
- R5: Mode code 5 (indexed) on register 9 or 11 issues the pointer plus the offset input as the address, and leaves the pointer unchanged.
- R6: Mode code 5 on register 8 or 10, or a mode code of 6 or 7, raises the illegal flag with no strobe and no writeback.
- R7: The address window of each side is inclusive, from its low bound to its high bound. An effective address outside the window, or one whose sum carries past the data width, raises the error flag and suppresses both the strobe and the writeback.
- R8: When the effective address is in the window but the post-modified value is outside it (including a carry past the data width), the strobe is still issued, the error flag is raised and the writeback is suppressed.
- R9: The X and Y sides work independently in the same cycle. A mode code of 0 produces no strobe, no flag and no writeback on that side.
- R10: The load port writes a pointer on the next edge (selector 0 to 3 means register 8 to 11). If a writeback targets the same pointer in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Pointer load enable |
| ld_sel | input | 2 | Pointer to load (0..3 means register 8..11) |
| ld_data | input | DW | Load value |
| x_reg | input | 4 | X-side register number |
| x_mode | input | 3 | X-side mode code |
| y_reg | input | 4 | Y-side register number |
| y_mode | input | 3 | Y-side mode code |
| idx_off | input | DW | Offset register value used by indexed mode |
| x_lo | input | DW | X window low bound |
| x_hi | input | DW | X window high bound |
| y_lo | input | DW | Y window low bound |
| y_hi | input | DW | Y window high bound |
| x_addr | output | DW | X read address |
| x_vld | output | 1 | X read strobe |
| x_err | output | 1 | X range error |
| x_ill | output | 1 | X illegal selection or mode |
| x_wb_en | output | 1 | X pointer writeback enable |
| x_wb_data | output | DW | X post-modified pointer value |
| y_addr | output | DW | Y read address |
| y_vld | output | 1 | Y read strobe |
| y_err | output | 1 | Y range error |
| y_ill | output | 1 | Y illegal selection or mode |
| y_wb_en | output | 1 | Y pointer writeback enable |
| y_wb_data | output | DW | Y post-modified pointer value |

## Verification
The bench builds the block with an 8-bit data width, with pointers and bounds drawn at random across the whole 8-bit range. At this width, the carry past the top of the address range, in both indexed sums and post-modify steps, is hit often instead of never. Window edges that sit one step away from a pointer are also common. This makes the difference between R7 and R8, and the inclusive bound behaviour, reachable without hand-picking every case.

// File: rtl/dpagu_pkg.sv
// Shared definitions for the dual-operand prefetch address unit.
// Assumes a 3-bit mode code per operand; codes 6 and 7 are reserved.
package dpagu_pkg;
    typedef enum logic [2:0] {
        AM_NONE  = 3'd0,
        AM_IND   = 3'd1,
        AM_POST2 = 3'd2,
        AM_POST4 = 3'd3,
        AM_POST6 = 3'd4,
        AM_INDEX = 3'd5
    } amode_e;

    localparam int unsigned PTR_COUNT = 4;
    localparam logic [3:0]  X_BASE    = 4'd8;
    localparam logic [3:0]  Y_BASE    = 4'd10;
endpackage

// File: rtl/dpagu_side.sv
// One address path (X or Y). It combinationally decodes the register number
// and mode, forms the effective address and the post-modified value, checks
// both against the inclusive window [lo, hi], and produces the strobe, the flags
// and the writeback request.
// Assumes that PAIR_BASE is even; the odd register of the pair is the only one
// allowed to use indexed mode.
module dpagu_side
    import dpagu_pkg::*;
#(
    parameter int unsigned DW        = 16,
    parameter logic [3:0]  PAIR_BASE = 4'd8
) (
    input  logic [3:0]    reg_num,
    input  logic [2:0]    mode,
    input  logic [DW-1:0] ptr_even,
    input  logic [DW-1:0] ptr_odd,
    input  logic [DW-1:0] off,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output logic [DW-1:0] addr,
    output logic          vld,
    output logic          err,
    output logic          ill,
    output logic          wb_en,
    output logic          wb_sel,
    output logic [DW-1:0] wb_data
);
    logic          sel_ok, is_odd, active, legal, is_post, ea_bad, nxt_bad;
    logic [DW-1:0] base, step;
    logic [DW:0]   ea_wide, nxt_wide;

    // Decode the selection and mode, and pick the step size.
    always_comb begin
        sel_ok  = (reg_num[3:1] == PAIR_BASE[3:1]);
        is_odd  = reg_num[0];
        base    = is_odd ? ptr_odd : ptr_even;
        active  = (mode != AM_NONE);
        is_post = (mode == AM_POST2) || (mode == AM_POST4) || (mode == AM_POST6);
        unique case (mode)
            AM_POST2: step = DW'(2);
            AM_POST4: step = DW'(4);
            AM_POST6: step = DW'(6);
            default:  step = '0;
        endcase
        ill   = active && (!sel_ok || (mode > AM_INDEX) || ((mode == AM_INDEX) && !is_odd));
        legal = active && !ill;
    end

    // Form both addresses with a carry bit, then check them against the window.
    always_comb begin
        ea_wide  = {1'b0, base} + ((mode == AM_INDEX) ? {1'b0, off} : '0);
        nxt_wide = {1'b0, base} + {1'b0, step};
        ea_bad   = ea_wide[DW] || (ea_wide[DW-1:0] < lo) || (ea_wide[DW-1:0] > hi);
        nxt_bad  = is_post && (nxt_wide[DW] || (nxt_wide[DW-1:0] < lo) ||
                               (nxt_wide[DW-1:0] > hi));
    end

    // Drive the outputs of this side.
    always_comb begin
        addr    = ea_wide[DW-1:0];
        vld     = legal && !ea_bad;
        err     = legal && (ea_bad || nxt_bad);
        wb_en   = legal && is_post && !ea_bad && !nxt_bad;
        wb_sel  = is_odd;
        wb_data = nxt_wide[DW-1:0];
    end
endmodule

// File: rtl/dpagu_ptr_file.sv
// The four prefetch pointer registers. Pointers 0 and 1 take X-side writebacks,
// and pointers 2 and 3 take Y-side writebacks. A load to the same pointer in
// the same cycle overrides the writeback.
// Assumes that N is 4, split evenly between the two sides.
module dpagu_ptr_file #(
    parameter int unsigned DW = 16,
    parameter int unsigned N  = 4,
    localparam int unsigned SW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic [SW-1:0]         ld_sel,
    input  logic [DW-1:0]         ld_data,
    input  logic                  x_wb_en,
    input  logic                  x_wb_sel,
    input  logic [DW-1:0]         x_wb_data,
    input  logic                  y_wb_en,
    input  logic                  y_wb_sel,
    input  logic [DW-1:0]         y_wb_data,
    output logic [N-1:0][DW-1:0]  ptr_q
);
    for (genvar i = 0; i < N; i++) begin : g_ptr
        localparam bit IS_Y = (i >= N/2);
        logic wb_hit;
        logic [DW-1:0] wb_val;

        // Work out whether this pointer's side writes back to it.
        always_comb begin
            if (IS_Y) begin
                wb_hit = y_wb_en && (y_wb_sel == 1'(i % 2));
                wb_val = y_wb_data;
            end else begin
                wb_hit = x_wb_en && (x_wb_sel == 1'(i % 2));
                wb_val = x_wb_data;
            end
        end

        // Update the pointer: reset, then load, then writeback.
        always_ff @(posedge clk) begin
            if (!rst_n)                             ptr_q[i] <= '0;
            else if (ld_en && (ld_sel == SW'(i)))   ptr_q[i] <= ld_data;
            else if (wb_hit)                        ptr_q[i] <= wb_val;
        end
    end
endmodule

// File: rtl/dual_prefetch_agu.sv
// Top level of the dual-operand prefetch address unit. It ties the pointer
// file to one X path (registers 8 and 9) and one Y path (registers 10 and 11).
// Addresses and flags are combinational in the issue cycle, and writebacks land
// on the next edge.
// Assumes that the bounds and the offset are held stable by the caller during the issue cycle.
module dual_prefetch_agu
    import dpagu_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic [3:0]    x_reg,
    input  logic [2:0]    x_mode,
    input  logic [3:0]    y_reg,
    input  logic [2:0]    y_mode,
    input  logic [DW-1:0] idx_off,
    input  logic [DW-1:0] x_lo,
    input  logic [DW-1:0] x_hi,
    input  logic [DW-1:0] y_lo,
    input  logic [DW-1:0] y_hi,
    output logic [DW-1:0] x_addr,
    output logic          x_vld,
    output logic          x_err,
    output logic          x_ill,
    output logic          x_wb_en,
    output logic [DW-1:0] x_wb_data,
    output logic [DW-1:0] y_addr,
    output logic          y_vld,
    output logic          y_err,
    output logic          y_ill,
    output logic          y_wb_en,
    output logic [DW-1:0] y_wb_data
);
    logic [PTR_COUNT-1:0][DW-1:0] ptr_q;
    logic x_wb_sel, y_wb_sel;

    dpagu_ptr_file #(.DW(DW), .N(PTR_COUNT)) ptrs_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .x_wb_en(x_wb_en), .x_wb_sel(x_wb_sel), .x_wb_data(x_wb_data),
        .y_wb_en(y_wb_en), .y_wb_sel(y_wb_sel), .y_wb_data(y_wb_data),
        .ptr_q(ptr_q)
    );

    dpagu_side #(.DW(DW), .PAIR_BASE(X_BASE)) xside_i (
        .reg_num(x_reg), .mode(x_mode),
        .ptr_even(ptr_q[0]), .ptr_odd(ptr_q[1]),
        .off(idx_off), .lo(x_lo), .hi(x_hi),
        .addr(x_addr), .vld(x_vld), .err(x_err), .ill(x_ill),
        .wb_en(x_wb_en), .wb_sel(x_wb_sel), .wb_data(x_wb_data)
    );

    dpagu_side #(.DW(DW), .PAIR_BASE(Y_BASE)) yside_i (
        .reg_num(y_reg), .mode(y_mode),
        .ptr_even(ptr_q[2]), .ptr_odd(ptr_q[3]),
        .off(idx_off), .lo(y_lo), .hi(y_hi),
        .addr(y_addr), .vld(y_vld), .err(y_err), .ill(y_ill),
        .wb_en(y_wb_en), .wb_sel(y_wb_sel), .wb_data(y_wb_data)
    );
endmodule

// File: rtl/dpagu_checker.sv
// Property checker for dual_prefetch_agu, attached by bind. It relates the
// decode outputs to the port inputs and to the pointer registers over time.
// Assumes a synchronous active-low reset.
module dpagu_checker #(
    parameter int unsigned DW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ld_en,
    input logic [1:0]          ld_sel,
    input logic [DW-1:0]       ld_data,
    input logic [2:0]          x_mode,
    input logic [2:0]          y_mode,
    input logic [DW-1:0]       x_lo,
    input logic [DW-1:0]       x_hi,
    input logic [DW-1:0]       x_addr,
    input logic                x_vld,
    input logic                x_err,
    input logic                x_ill,
    input logic                x_wb_en,
    input logic                y_vld,
    input logic                y_err,
    input logic                y_ill,
    input logic                y_wb_en,
    input logic [3:0][DW-1:0]  ptr_q
);
    // Illegal selections never strobe or write back.
    p_ill_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_ill |-> (!x_vld && !x_wb_en && !x_err)) and (y_ill |-> (!y_vld && !y_wb_en && !y_err)));

    // A range error never writes back.
    p_err_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_err |-> !x_wb_en) and (y_err |-> !y_wb_en));

    // A strobed X address lies inside its window.
    p_vld_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        x_vld |-> ((x_addr >= x_lo) && (x_addr <= x_hi)));

    // Mode 0 is silent on both sides.
    p_none_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((x_mode == 3'd0) |-> !(x_vld || x_err || x_ill || x_wb_en)) and
        ((y_mode == 3'd0) |-> !(y_vld || y_err || y_ill || y_wb_en)));

    // A load always takes effect on the next edge.
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (ptr_q[$past(ld_sel)] == $past(ld_data)));

    // With no load and no writeback, the pointers hold their values.
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !x_wb_en && !y_wb_en) |=> $stable(ptr_q));
endmodule

bind dual_prefetch_agu dpagu_checker #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .x_mode(x_mode), .y_mode(y_mode), .x_lo(x_lo), .x_hi(x_hi),
    .x_addr(x_addr), .x_vld(x_vld), .x_err(x_err), .x_ill(x_ill), .x_wb_en(x_wb_en),
    .y_vld(y_vld), .y_err(y_err), .y_ill(y_ill), .y_wb_en(y_wb_en),
    .ptr_q(ptr_q)
);

// File: tb/dual_prefetch_agu_tb_top.sv
// Self-checking bench with a behavioural reference model, compared on every clock.
module dual_prefetch_agu_tb_top;
    localparam int DW   = 8;
    localparam int MAXV = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0;
    logic [1:0] ld_sel = '0;
    logic [DW-1:0] ld_data = '0, idx_off = '0;
    logic [3:0] x_reg = 4'd8, y_reg = 4'd10;
    logic [2:0] x_mode = '0, y_mode = '0;
    logic [DW-1:0] x_lo = '0, x_hi = '1, y_lo = '0, y_hi = '1;
    logic [DW-1:0] x_addr, x_wb_data, y_addr, y_wb_data;
    logic x_vld, x_err, x_ill, x_wb_en, y_vld, y_err, y_ill, y_wb_en;

    int n_vec = 0, n_bad = 0;
    int mptr [4];

    always #10 clk = ~clk;

    dual_prefetch_agu #(.DW(DW)) dut_i (.*);

    // Reference model of one side.
    task automatic model_side(input int side, input int rn, input int md, input int off,
                              input int lo, input int hi,
                              output bit v, output bit e, output bit il, output bit wb,
                              output int ad, output int wd, output int wi, output string req);
        int base_reg, p, ea, nx, st;
        bit sel_ok, eab, nxb, post;
        base_reg = (side == 0) ? 8 : 10;
        v = 0; e = 0; il = 0; wb = 0; ad = 0; wd = 0; wi = 0; req = "R9";
        if (md == 0) return;
        sel_ok = (rn == base_reg) || (rn == base_reg + 1);
        if (!sel_ok) begin il = 1; req = "R2"; return; end
        if (md > 5 || (md == 5 && rn == base_reg)) begin il = 1; req = "R6"; return; end
        wi = rn - 8;
        p  = mptr[wi];
        st = (md == 2) ? 2 : (md == 3) ? 4 : (md == 4) ? 6 : 0;
        post = (st != 0);
        ea = (md == 5) ? p + off : p;
        nx = p + st;
        eab = (ea > MAXV) || (ea < lo) || (ea > hi);
        nxb = post && ((nx > MAXV) || (nx < lo) || (nx > hi));
        ad = ea & MAXV; wd = nx & MAXV;
        v  = !eab;
        e  = eab || nxb;
        wb = post && !eab && !nxb;
        req = eab ? "R7" : nxb ? "R8" : (md == 1) ? "R3" : (md == 5) ? "R5" : "R4";
    endtask

    bit xv, xe, xi, xw, yv, ye, yi, yw;
    int xa, xd, xwi, ya, yd, ywi;
    string xr, yr;

    // Compare both sides against the model, away from the clock edge.
    task automatic compare();
        model_side(0, x_reg, x_mode, idx_off, x_lo, x_hi, xv, xe, xi, xw, xa, xd, xwi, xr);
        model_side(1, y_reg, y_mode, idx_off, y_lo, y_hi, yv, ye, yi, yw, ya, yd, ywi, yr);
        n_vec++;
        if (x_vld !== xv || x_err !== xe || x_ill !== xi || x_wb_en !== xw ||
            (xv && int'(x_addr) != xa) || (xw && int'(x_wb_data) != xd)) begin
            n_bad++;
            $display("FAIL %s X: got vld%0b err%0b ill%0b wb%0b addr%0h wbd%0h exp vld%0b err%0b ill%0b wb%0b addr%0h wbd%0h",
                     xr, x_vld, x_err, x_ill, x_wb_en, x_addr, x_wb_data, xv, xe, xi, xw, xa, xd);
        end
        if (y_vld !== yv || y_err !== ye || y_ill !== yi || y_wb_en !== yw ||
            (yv && int'(y_addr) != ya) || (yw && int'(y_wb_data) != yd)) begin
            n_bad++;
            $display("FAIL %s Y: got vld%0b err%0b ill%0b wb%0b addr%0h wbd%0h exp vld%0b err%0b ill%0b wb%0b addr%0h wbd%0h",
                     yr, y_vld, y_err, y_ill, y_wb_en, y_addr, y_wb_data, yv, ye, yi, yw, ya, yd);
        end
    endtask

    // One cycle: compare at the falling edge, then update the model at the rising edge (loads win, R10).
    task automatic step();
        @(negedge clk);
        compare();
        @(posedge clk);
        if (xw) mptr[xwi] = xd;
        if (yw) mptr[ywi] = yd;
        if (ld_en) mptr[ld_sel] = ld_data;
        #1;
        ld_en = 1'b0;
    endtask

    task automatic check_ptr(input int idx, input int exp, input string req);
        int got;
        x_mode = 3'd1; y_mode = 3'd1; x_lo = '0; x_hi = '1; y_lo = '0; y_hi = '1;
        if (idx < 2) x_reg = 4'(8 + idx); else y_reg = 4'(8 + idx);
        @(negedge clk);
        got = (idx < 2) ? int'(x_addr) : int'(y_addr);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s pointer %0d: got %0h exp %0h", req, idx, got, exp);
        end
        @(posedge clk); #1;
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mptr[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: all pointers read as zero after reset.
        for (int i = 0; i < 4; i++) check_ptr(i, 0, "R1");
        // R10: load each pointer, then read it back.
        for (int i = 0; i < 4; i++) begin
            x_mode = 3'd0; y_mode = 3'd0;
            ld_en = 1'b1; ld_sel = 2'(i); ld_data = DW'(8'h10 * (i + 1));
            step();
        end
        for (int i = 0; i < 4; i++) check_ptr(i, 16 * (i + 1), "R10");
        // R4 on both sides in the same cycle (R9), then indexed R5 and illegal R6/R2.
        x_reg = 4'd8; x_mode = 3'd2; y_reg = 4'd11; y_mode = 3'd4; step();
        x_reg = 4'd9; x_mode = 3'd5; idx_off = 8'h07; y_reg = 4'd10; y_mode = 3'd5; step();
        x_reg = 4'd10; x_mode = 3'd1; y_reg = 4'd9; y_mode = 3'd7; step();
        // R8: a post-modify that carries past the top of the range.
        ld_en = 1'b1; ld_sel = 2'd3; ld_data = 8'hFE; x_mode = 3'd0; y_mode = 3'd0; step();
        y_reg = 4'd11; y_mode = 3'd3; step();
        // R7: an address just outside the inclusive window.
        x_reg = 4'd8; x_mode = 3'd1; x_lo = 8'h13; x_hi = 8'h40; step();
        x_lo = 8'h12; x_hi = 8'h12; step();
        // R10: a load overrides a same-cycle writeback.
        x_lo = '0; x_hi = '1; x_mode = 3'd2; ld_en = 1'b1; ld_sel = 2'd0; ld_data = 8'h55; step();
        check_ptr(0, 8'h55, "R10");
        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            int a, b;
            x_reg = 4'($urandom_range(10) < 8 ? 8 + $urandom_range(1) : $urandom_range(15));
            y_reg = 4'($urandom_range(10) < 8 ? 10 + $urandom_range(1) : $urandom_range(15));
            x_mode = 3'($urandom_range(7)); y_mode = 3'($urandom_range(7));
            idx_off = DW'($urandom_range(MAXV));
            a = $urandom_range(MAXV); b = $urandom_range(MAXV);
            x_lo = DW'((a < b) ? a : b); x_hi = DW'((a < b) ? b : a);
            a = $urandom_range(MAXV); b = $urandom_range(MAXV);
            y_lo = DW'((a < b) ? a : b); y_hi = DW'((a < b) ? b : a);
            if ($urandom_range(9) == 0) begin
                ld_en = 1'b1; ld_sel = 2'($urandom_range(3)); ld_data = DW'($urandom_range(MAXV));
            end
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule